// File: doc/BRIEF.md
# ADC Sample Capture Buffer with Clock-Rate Crossing

This block takes groups of converter samples that arrive on the converter's own clock and stores them in a sample memory clocked by a fixed system clock. A 16-entry dual-clock FIFO is the only place where the two clock domains meet. All control logic sits in the system domain: it drains the FIFO and writes one memory word per popped entry. Each FIFO entry carries up to four sample lanes, which a front end that deserializes a double-rate bus can fill in one converter clock. A packing mode selects how many of those lanes are kept in each memory word. With more lanes per word, the sample rate can exceed the memory clock rate.

Software, or a host-side sequencer, chooses a packing mode and a word count, then pulses `arm`. Capture starts with the first FIFO entry popped after the arm. It stops once the requested number of memory words has been written, and `done` then rises. The memory is read back one word at a time through a registered address/data port. If the converter side ever tries to write into a full FIFO, the sample group is dropped and a sticky `overflow` flag records that the capture cannot be trusted.

The controller has three states:
- `ST_IDLE`: after reset. FIFO entries are popped and discarded.
- `ST_RUN`: capturing. Each popped entry is packed and written to the memory.
- `ST_DONE`: capture complete. FIFO entries are popped and discarded, and readback is allowed.

The transitions are:
- IDLE→RUN on `arm`.
- RUN→DONE when the entry that completes the word count is written.
- DONE→RUN on `arm`.

An `arm` pulse while in RUN is not accepted.

Top module: `adc_capture_buffer`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `rd_valid` are all 0.
- R2: An `arm` pulse in IDLE or DONE makes `busy` 1 and `done` 0 from the next system clock. The first FIFO entry popped after that is stored at memory address 0, and later entries are stored at consecutive addresses.
- R3: Capture stops after exactly `word_count` memory words, where a `word_count` of 0 means the full memory depth (64 words). `done` then becomes 1, `busy` becomes 0, and addresses at or above the count keep their previous contents.
- R4: Sample lane k occupies bits [8k+7:8k] of both the input word and the memory word. `pack_mode` 0 keeps lane 0 only, 1 keeps lanes 0–1, and 2 or 3 keeps all four lanes. Lanes that are not kept are stored as zero. The mode is latched at arm.
- R5: With `adc_valid` high on every converter clock and the converter clock equal to the system clock, no entry is lost and `overflow` stays 0. This holds for a full-depth capture.
- R6: A write attempted while the 16-entry FIFO is full is dropped, and `overflow` becomes 1 and stays 1.
- R7: An accepted `arm` clears `overflow`.
- R8: When `busy` is 0, a cycle with `rd_en` high returns the word at `rd_addr` on `rd_data`, with `rd_valid` high, exactly one system clock later.
- R9: While `busy` is 1, `rd_en` is ignored: `rd_valid` stays 0 and `rd_data` holds its value.
- R10: FIFO entries that arrive in IDLE or DONE are discarded and do not change the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the memory and control logic |
| adc_clk | input | 1 | Converter-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| adc_valid | input | 1 | A sample group is present on `adc_data` (converter domain) |
| adc_data | input | 32 | Four 8-bit sample lanes, lane k in bits [8k+7:8k] |
| arm | input | 1 | One-cycle pulse that starts a capture |
| pack_mode | input | 2 | Lanes kept per memory word: 0→1, 1→2, 2/3→4 |
| word_count | input | 7 | Number of memory words to capture, where 0 means 64 |
| busy | output | 1 | A capture is in progress |
| done | output | 1 | The last capture has completed |
| overflow | output | 1 | Sticky flag: a converter-side group was dropped |
| rd_en | input | 1 | Readback request |
| rd_addr | input | 6 | Readback word address |
| rd_data | output | 32 | Readback word, one cycle after the request |
| rd_valid | output | 1 | `rd_data` was updated by the previous request |

## Verification
The hardest condition to reach is a FIFO that is genuinely full. This only happens when the converter clock outruns the system drain rate for long enough to fill all 16 entries. The bench therefore speeds the converter clock up to twice the system clock and streams far more groups than the capture needs. It then checks both that the sticky flag is set and that the stored sequence has a gap. The opposite edge case is sustained operation with the two clocks at exactly equal rates. There, a full-depth capture must come through with no gap, despite the synchronizer latency between the domains.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cap_state_t;

    localparam logic [1:0] PACK_ONE = 2'd0;
    localparam logic [1:0] PACK_TWO = 2'd1;

endpackage

// File: rtl/cap_async_fifo.sv
`timescale 1ns/1ps
module cap_async_fifo #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wvalid,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rpop,
    output logic [W-1:0]  rdata,
    output logic          rempty,
    output logic [AW:0]   drop_gray_r
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];
    logic [AW:0]  wbin, wgray, rbin, rgray;
    logic [AW:0]  rq1, rq2, wq1, wq2;
    logic [AW:0]  dbin, dgray, dq1;
    logic         full;
    logic [AW:0]  wbin_nx, rbin_nx, dbin_nx;

    assign full    = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign wbin_nx = wbin + 1'b1;
    assign dbin_nx = dbin + 1'b1;

    // converter-side pointer and drop counter
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            dbin  <= '0;
            dgray <= '0;
        end else if (wvalid && !full) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end else if (wvalid && full) begin
            dbin  <= dbin_nx;
            dgray <= dbin_nx ^ (dbin_nx >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wvalid && !full) begin
            store[wbin[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            rq1 <= '0;
            rq2 <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
        end
    end

    // system-side pointer
    assign rempty  = (rgray == wq2);
    assign rdata   = store[rbin[AW-1:0]];
    assign rbin_nx = rbin + 1'b1;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rpop && !rempty) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            wq1         <= '0;
            wq2         <= '0;
            dq1         <= '0;
            drop_gray_r <= '0;
        end else begin
            wq1         <= wgray;
            wq2         <= wq1;
            dq1         <= dgray;
            drop_gray_r <= dq1;
        end
    end

    // R5
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R6
    full_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wvalid && full) |=> (wbin == $past(wbin)));

    // R5
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/cap_buf_ram.sv
`timescale 1ns/1ps
module cap_buf_ram #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/cap_ctrl.sv
`timescale 1ns/1ps
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int SW     = 8,
    parameter int LANES  = 4,
    parameter int MEM_AW = 6,
    parameter int DROP_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic [1:0]            pack_mode,
    input  logic [MEM_AW:0]       word_count,
    input  logic                  fifo_empty,
    input  logic [SW*LANES-1:0]   fifo_data,
    input  logic [DROP_W-1:0]     drop_gray,
    output logic                  fifo_pop,
    output logic                  mem_we,
    output logic [MEM_AW-1:0]     mem_waddr,
    output logic [SW*LANES-1:0]   mem_wdata,
    output logic                  busy,
    output logic                  done,
    output logic                  overflow
);
    localparam int CNT_W = MEM_AW + 1;
    localparam int DEPTH = 1 << MEM_AW;
    localparam int LN_W  = $clog2(LANES) + 1;

    cap_state_t          state, state_nx;
    logic [CNT_W-1:0]    wr_cnt, target_q;
    logic [1:0]          mode_q;
    logic [LN_W-1:0]     lanes_used;
    logic [DROP_W-1:0]   drop_last;
    logic                arm_acc;
    logic                last_word;

    assign arm_acc   = arm && (state != ST_RUN);
    assign last_word = (wr_cnt == target_q - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (arm) state_nx = ST_RUN;
            ST_RUN:  if (!fifo_empty && last_word) state_nx = ST_DONE;
            ST_DONE: if (arm) state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fifo_pop = !fifo_empty;
        mem_we   = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN: begin
                busy   = 1'b1;
                mem_we = !fifo_empty;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // capture bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt   <= '0;
            target_q <= CNT_W'(DEPTH);
            mode_q   <= PACK_ONE;
        end else if (arm_acc) begin
            wr_cnt   <= '0;
            target_q <= (word_count == '0) ? CNT_W'(DEPTH) : word_count;
            mode_q   <= pack_mode;
        end else if (mem_we) begin
            wr_cnt   <= wr_cnt + 1'b1;
        end
    end

    assign mem_waddr = wr_cnt[MEM_AW-1:0];

    always_comb begin
        if (mode_q == PACK_ONE)      lanes_used = LN_W'(1);
        else if (mode_q == PACK_TWO) lanes_used = LN_W'(2);
        else                         lanes_used = LN_W'(LANES);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign mem_wdata[k*SW +: SW] =
            (k < int'(lanes_used)) ? fifo_data[k*SW +: SW] : '0;
    end

    // sticky overflow from the synchronized drop counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_last <= '0;
            overflow  <= 1'b0;
        end else begin
            drop_last <= drop_gray;
            if (arm_acc) begin
                overflow <= 1'b0;
            end else if (drop_gray != drop_last) begin
                overflow <= 1'b1;
            end
        end
    end

    // R2
    arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !busy) |=> (busy && !done && wr_cnt == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wr_cnt < target_q));

    // R3
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_we));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(arm && !busy)) |=> overflow);

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !busy) |=> !overflow);

endmodule

// File: rtl/adc_capture_buffer.sv
`timescale 1ns/1ps
module adc_capture_buffer #(
    parameter int SW      = 8,
    parameter int LANES   = 4,
    parameter int FIFO_AW = 4,
    parameter int MEM_AW  = 6
) (
    input  logic                  sys_clk,
    input  logic                  adc_clk,
    input  logic                  rst_n,
    input  logic                  adc_valid,
    input  logic [SW*LANES-1:0]   adc_data,
    input  logic                  arm,
    input  logic [1:0]            pack_mode,
    input  logic [MEM_AW:0]       word_count,
    output logic                  busy,
    output logic                  done,
    output logic                  overflow,
    input  logic                  rd_en,
    input  logic [MEM_AW-1:0]     rd_addr,
    output logic [SW*LANES-1:0]   rd_data,
    output logic                  rd_valid
);
    localparam int WW     = SW * LANES;
    localparam int DROP_W = FIFO_AW + 1;

    logic [WW-1:0]     fifo_data;
    logic              fifo_empty, fifo_pop;
    logic [DROP_W-1:0] drop_gray;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [WW-1:0]     mem_wdata;
    logic              rd_go;

    cap_async_fifo #(.W(WW), .AW(FIFO_AW)) u_fifo (
        .wclk        (adc_clk),
        .rst_n       (rst_n),
        .wvalid      (adc_valid),
        .wdata       (adc_data),
        .rclk        (sys_clk),
        .rpop        (fifo_pop),
        .rdata       (fifo_data),
        .rempty      (fifo_empty),
        .drop_gray_r (drop_gray)
    );

    cap_ctrl #(.SW(SW), .LANES(LANES), .MEM_AW(MEM_AW), .DROP_W(DROP_W)) u_ctrl (
        .clk        (sys_clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .pack_mode  (pack_mode),
        .word_count (word_count),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .drop_gray  (drop_gray),
        .fifo_pop   (fifo_pop),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .done       (done),
        .overflow   (overflow)
    );

    assign rd_go = rd_en && !busy;

    cap_buf_ram #(.W(WW), .AW(MEM_AW)) u_ram (
        .clk   (sys_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (rd_go),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
        end
    end

    // R8
    rd_latency_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (rd_en && !busy) |=> rd_valid);

    // R9
    rd_block_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (rd_en && busy) |=> (!rd_valid && $stable(rd_data)));

endmodule

// File: tb/adc_capture_buffer_tb.sv
`timescale 1ns/1ps
module adc_capture_buffer_tb;
    localparam int SW = 8, LANES = 4, MEM_AW = 6, WW = SW * LANES;

    logic sys_clk = 1'b0, adc_clk = 1'b0, rst_n = 1'b0;
    logic adc_valid = 1'b0;
    logic [WW-1:0] adc_data = '0;
    logic arm = 1'b0;
    logic [1:0] pack_mode = 2'd0;
    logic [MEM_AW:0] word_count = '0;
    logic busy, done, overflow, rd_valid;
    logic rd_en = 1'b0;
    logic [MEM_AW-1:0] rd_addr = '0;
    logic [WW-1:0] rd_data;

    real adc_half = 2.5;
    int  checks = 0, fails = 0;
    bit  finished = 1'b0;

    always #2 sys_clk = ~sys_clk;
    always #(adc_half) adc_clk = ~adc_clk;

    adc_capture_buffer u_dut (
        .sys_clk(sys_clk), .adc_clk(adc_clk), .rst_n(rst_n),
        .adc_valid(adc_valid), .adc_data(adc_data),
        .arm(arm), .pack_mode(pack_mode), .word_count(word_count),
        .busy(busy), .done(done), .overflow(overflow),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] raw_word(input int i, input logic [7:0] seed);
        logic [WW-1:0] w;
        for (int k = 0; k < LANES; k++) w[k*SW +: SW] = seed + 8'(4*i + k);
        return w;
    endfunction

    function automatic logic [WW-1:0] exp_word(input int i, input logic [7:0] seed,
                                               input int mode);
        logic [WW-1:0] w;
        int n;
        w = raw_word(i, seed);
        n = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        for (int k = 0; k < LANES; k++) if (k >= n) w[k*SW +: SW] = '0;
        return w;
    endfunction

    task automatic sys_wait(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic do_arm(input logic [1:0] mode, input int cnt);
        @(negedge sys_clk);
        pack_mode  = mode;
        word_count = (MEM_AW+1)'(cnt);
        arm = 1'b1;
        @(negedge sys_clk);
        arm = 1'b0;
    endtask

    task automatic adc_stream(input int first, input int n, input logic [7:0] seed);
        for (int i = first; i < first + n; i++) begin
            @(negedge adc_clk);
            adc_valid = 1'b1;
            adc_data  = raw_word(i, seed);
        end
        @(negedge adc_clk);
        adc_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge sys_clk);
            t++;
        end
        chk(done && !busy, req, {30'd0, busy, done}, 32'd1);
    endtask

    task automatic read_word(input int addr, output logic [WW-1:0] val);
        @(negedge sys_clk);
        rd_addr = MEM_AW'(addr);
        rd_en   = 1'b1;
        @(negedge sys_clk);
        rd_en = 1'b0;
        val   = rd_data;
        chk(rd_valid == 1'b1, "R8 rd_valid after one cycle", 32'(rd_valid), 32'd1);
    endtask

    task automatic check_words(input int lo, input int hi, input int base_i,
                               input logic [7:0] seed, input int mode, input string req);
        logic [WW-1:0] v;
        for (int a = lo; a < hi; a++) begin
            read_word(a, v);
            chk(v == exp_word(a - lo + base_i, seed, mode), req, v,
                exp_word(a - lo + base_i, seed, mode));
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !overflow && !rd_valid, "R1 reset outputs",
            {28'd0, busy, done, overflow, rd_valid}, 32'd0);
    endtask

    task automatic t_single();
        do_arm(2'd0, 8);
        chk(busy && !done, "R2 busy after arm", {30'd0, busy, done}, 32'd2);
        adc_stream(0, 8, 8'h10);
        wait_done("R3 done after 8 words");
        check_words(0, 8, 0, 8'h10, 0, "R4 one lane per word (R2 order)");
        chk(!overflow, "R6 no overflow at low rate", 32'(overflow), 32'd0);
    endtask

    task automatic t_pair();
        do_arm(2'd1, 8);
        adc_stream(0, 8, 8'h40);
        wait_done("R3 done pair mode");
        check_words(0, 8, 0, 8'h40, 1, "R4 two lanes per word");
    endtask

    task automatic t_quad_short();
        logic [WW-1:0] v;
        do_arm(2'd2, 6);
        adc_stream(0, 8, 8'h80);
        wait_done("R3 done after 6 words");
        sys_wait(20);
        check_words(0, 6, 0, 8'h80, 2, "R4 four lanes per word");
        read_word(6, v);
        chk(v == exp_word(6, 8'h40, 1), "R3 address 6 kept", v, exp_word(6, 8'h40, 1));
        read_word(7, v);
        chk(v == exp_word(7, 8'h40, 1), "R10 trailing words discarded", v,
            exp_word(7, 8'h40, 1));
    endtask

    task automatic t_idle_discard();
        logic [WW-1:0] v;
        adc_stream(0, 4, 8'hC0);
        sys_wait(20);
        read_word(0, v);
        chk(v == exp_word(0, 8'h80, 2), "R10 words in DONE not stored", v,
            exp_word(0, 8'h80, 2));
        chk(done && !busy, "R10 state stays DONE", {30'd0, busy, done}, 32'd1);
    endtask

    task automatic t_read_block();
        logic [WW-1:0] held;
        do_arm(2'd0, 4);
        adc_stream(0, 2, 8'h20);
        sys_wait(20);
        chk(busy, "R9 still capturing", 32'(busy), 32'd1);
        held = rd_data;
        @(negedge sys_clk);
        rd_addr = 6'd5;
        rd_en   = 1'b1;
        @(negedge sys_clk);
        rd_en = 1'b0;
        chk(!rd_valid, "R9 rd_valid stays low while busy", 32'(rd_valid), 32'd0);
        chk(rd_data == held, "R9 rd_data holds while busy", rd_data, held);
        adc_stream(2, 2, 8'h20);
        wait_done("R3 done after 4 words");
        check_words(0, 4, 0, 8'h20, 0, "R2 consecutive addresses");
    endtask

    task automatic t_full_rate();
        adc_half = 2.0;
        sys_wait(4);
        do_arm(2'd0, 0);
        adc_stream(0, 64, 8'h00);
        wait_done("R3 word_count 0 means 64");
        chk(!overflow, "R5 no overflow at equal rate", 32'(overflow), 32'd0);
        check_words(0, 64, 0, 8'h00, 0, "R5 lossless full-rate capture");
    endtask

    task automatic t_overflow();
        logic [WW-1:0] v;
        adc_half = 1.0;
        sys_wait(4);
        do_arm(2'd0, 0);
        adc_stream(0, 200, 8'h00);
        adc_half = 2.5;
        wait_done("R3 done under overflow");
        chk(overflow, "R6 overflow set", 32'(overflow), 32'd1);
        sys_wait(30);
        chk(overflow, "R6 overflow sticky", 32'(overflow), 32'd1);
        read_word(63, v);
        chk(v != exp_word(63, 8'h00, 0), "R6 samples were dropped", v,
            exp_word(63, 8'h00, 0));
    endtask

    task automatic t_clear();
        do_arm(2'd0, 1);
        sys_wait(3);
        chk(!overflow, "R7 overflow cleared by arm", 32'(overflow), 32'd0);
        adc_stream(0, 1, 8'h55);
        wait_done("R3 single-word capture");
    endtask

    initial begin
        sys_wait(10);
        rst_n = 1'b1;
        sys_wait(2);
        t_reset();
        t_single();
        t_pair();
        t_quad_short();
        t_idle_discard();
        t_read_block();
        t_full_rate();
        t_overflow();
        t_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule